// File: doc/BRIEF.md
# Programmable Duty-Cycle Clock Prescaler

This block turns the system clock into a slower clock for an analog-to-digital converter. The high phase and the low phase of that clock are set by two separate fields of different widths. Together they set the frequency, and because they are independent they also set the duty cycle, which may be asymmetric. Divide ratios run from 2 to 40.

One shared down counter times both phases. When it reaches zero, the output level flips and the counter is reloaded from the field that belongs to the new phase. The fields are read only at that moment, so software can rewrite them at any time without disturbing the phase that is in progress. Downstream logic does not clock on the divided level. Instead it uses a one-cycle enable pulse that marks each rising edge of that level.

Top module: `prescale_duty_clk`

## Requirements
- R1: The high phase of `clk_lvl` lasts `hi_len + 1` system-clock cycles. `hi_len` is an unsigned 5-bit value, so the range is 1 to 32 cycles.
- R2: The low phase of `clk_lvl` lasts `lo_len + 1` system-clock cycles. `lo_len` is an unsigned 3-bit value, so the range is 1 to 8 cycles.
- R3: While `rst` (synchronous, active high) is asserted, `clk_lvl` and `rise_en` are 0. The first low phase after `rst` is released lasts `lo_len + 1` cycles, counted from the first cycle after the last reset edge.
- R4: `rise_en` is 1 for exactly the first cycle in which `clk_lvl` is 1 after having been 0, and it is 0 in every other cycle.
- R5: With both fields at 0, `clk_lvl` toggles every cycle (divide by 2), and `rise_en` pulses every second cycle.
- R6: With `hi_len` = 31 and `lo_len` = 7, the period is 40 cycles: 32 high followed by 8 low.
- R7: Each field is sampled only at the clock edge that starts its phase. A change made in the middle of a phase leaves that phase's length unchanged, and the next phase of that kind uses the new value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| hi_len | input | 5 | High-phase length minus one |
| lo_len | input | 3 | Low-phase length minus one |
| clk_lvl | output | 1 | Divided clock level |
| rise_en | output | 1 | One-cycle pulse on each rising edge of `clk_lvl` |

## Verification
The hardest case to reach is a field rewrite that lands strictly inside a phase, with the two field kinds rewritten in different phases. The stimulus counts cycles from a measured phase start, rewrites `hi_len` a few cycles into a long high phase, and then rewrites `lo_len` in the middle of the following low phase. It then measures that both interrupted phases kept their old lengths and that the next phases took the new values. The reset test releases `rst` at a known cycle, so the first low phase can be counted exactly.

// File: rtl/prescale_duty_clk.sv
module prescale_duty_clk #(
  parameter int HI_W = 5,
  parameter int LO_W = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [HI_W-1:0] hi_len,
  input  logic [LO_W-1:0] lo_len,
  output logic            clk_lvl,
  output logic            rise_en
);

  localparam int CNT_W = (HI_W > LO_W) ? HI_W : LO_W;

  logic [CNT_W-1:0] cnt;
  logic             phase;
  logic             at_zero;

  assign at_zero = (cnt == '0);
  assign clk_lvl = phase;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= 1'b0;
      cnt     <= CNT_W'(lo_len);
      rise_en <= 1'b0;
    end else if (at_zero) begin
      phase   <= ~phase;
      cnt     <= phase ? CNT_W'(lo_len) : CNT_W'(hi_len);
      rise_en <= ~phase;
    end else begin
      cnt     <= cnt - 1'b1;
      rise_en <= 1'b0;
    end
  end

endmodule

// File: rtl/prescale_duty_clk_chk.sv
module prescale_duty_clk_chk #(
  parameter int HI_W  = 5,
  parameter int LO_W  = 3,
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic [HI_W-1:0]  hi_len,
  input logic [LO_W-1:0]  lo_len,
  input logic             clk_lvl,
  input logic             rise_en,
  input logic [CNT_W-1:0] cnt
);

  a_r1_high_load: assert property (@(posedge clk) disable iff (rst)
    $rose(clk_lvl) |-> cnt == CNT_W'($past(hi_len)));

  a_r2_low_load: assert property (@(posedge clk) disable iff (rst)
    $fell(clk_lvl) |-> cnt == CNT_W'($past(lo_len)));

  a_r4_pulse_on_rise: assert property (@(posedge clk) disable iff (rst)
    rise_en |-> $rose(clk_lvl));

  a_r4_rise_has_pulse: assert property (@(posedge clk) disable iff (rst)
    $rose(clk_lvl) |-> rise_en);

  a_r7_level_holds: assert property (@(posedge clk) disable iff (rst)
    cnt != '0 |=> $stable(clk_lvl));

  a_r7_counts_down: assert property (@(posedge clk) disable iff (rst)
    cnt != '0 |=> cnt == $past(cnt) - 1'b1);

endmodule

bind prescale_duty_clk prescale_duty_clk_chk #(
  .HI_W(HI_W), .LO_W(LO_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst(rst), .hi_len(hi_len), .lo_len(lo_len),
  .clk_lvl(clk_lvl), .rise_en(rise_en), .cnt(cnt)
);

// File: tb/sim_prescale_duty_clk.sv
module sim_prescale_duty_clk;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [4:0] hi_len = '0;
  logic [2:0] lo_len = '0;
  logic       clk_lvl;
  logic       rise_en;

  int checks = 0;
  int errors = 0;
  logic prev_lvl = 1'b0;
  bit done = 1'b0;

  prescale_duty_clk u0 (
    .clk(clk), .rst(rst), .hi_len(hi_len), .lo_len(lo_len),
    .clk_lvl(clk_lvl), .rise_en(rise_en)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // R4: pulse monitor, sampled at negedge
  always @(negedge clk) begin
    if (!rst && !done)
      check("R4 rise_en", int'(rise_en), int'(clk_lvl && !prev_lvl));
    prev_lvl <= rst ? 1'b0 : clk_lvl;
  end

  task automatic meas(input logic lvl, output int n);
    n = 0;
    while (clk_lvl == lvl && n < 100) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic sync_fall();
    int g = 0;
    while (clk_lvl != 1'b1 && g < 100) begin g++; @(negedge clk); end
    while (clk_lvl != 1'b0 && g < 200) begin g++; @(negedge clk); end
  endtask

  task automatic t_reset();
    int n;
    rst = 1'b1; lo_len = 3'd4; hi_len = 5'd2;
    repeat (3) @(negedge clk);
    check("R3 clk_lvl in reset", int'(clk_lvl), 0);
    check("R3 rise_en in reset", int'(rise_en), 0);
    rst = 1'b0;
    meas(1'b0, n);
    check("R3 first low", n, 5);
    meas(1'b1, n);
    check("R1 high after reset", n, 3);
  endtask

  task automatic t_ratio(input int h, input int l, input string req);
    int n;
    hi_len = 5'(h); lo_len = 3'(l);
    sync_fall();
    for (int k = 0; k < 2; k++) begin
      meas(1'b0, n); check({req, " low"}, n, l + 1);
      meas(1'b1, n); check({req, " high"}, n, h + 1);
    end
  endtask

  task automatic t_div2();
    int n;
    hi_len = '0; lo_len = '0;
    sync_fall();
    for (int k = 0; k < 4; k++) begin
      meas(1'b0, n); check("R5 low", n, 1);
      meas(1'b1, n); check("R5 high", n, 1);
    end
  endtask

  task automatic t_max();
    int lo_n, hi_n;
    hi_len = 5'd31; lo_len = 3'd7;
    sync_fall();
    meas(1'b0, lo_n);
    meas(1'b1, hi_n);
    check("R6 period", lo_n + hi_n, 40);
    check("R6 high", hi_n, 32);
  endtask

  task automatic t_midchange();
    int n;
    hi_len = 5'd20; lo_len = 3'd2;
    sync_fall();
    meas(1'b0, n); check("R7 low before", n, 3);
    n = 0;
    while (clk_lvl && n < 100) begin
      n++;
      if (n == 6) hi_len = 5'd3;
      @(negedge clk);
    end
    check("R7 interrupted high", n, 21);
    n = 0;
    while (!clk_lvl && n < 100) begin
      n++;
      if (n == 2) lo_len = 3'd6;
      @(negedge clk);
    end
    check("R7 interrupted low", n, 3);
    meas(1'b1, n); check("R7 new high", n, 4);
    meas(1'b0, n); check("R7 new low", n, 7);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    t_ratio(9, 2, "R1 R2 asym");
    t_ratio(1, 6, "R1 R2 short high");
    t_div2();
    t_max();
    t_midchange();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule